// File: doc/BRIEF.md
# Fully Associative Word Cache

This block sits between a processor request port and a main-memory port. It keeps a small number of entries, each holding a valid flag, the word address of a stored word, and the 32-bit word itself. Every accepted request compares its word address against all stored addresses at once. A read that finds its word returns it from the local store. A read that misses fetches the word over the memory port and places it in an entry. When the cache is full, one resident entry is evicted.

Writes go through to memory every time. A write that finds its word also updates the local copy. A write that misses leaves the cache unchanged. The eviction policy is fixed when the block is built: least recently used, cyclic in fill order, or pseudo-random from a free-running shift register.

Top module: `fa_cache`

## Requirements
- R1: The stored tag is bits 31:2 of the byte address. Each lookup compares it against every entry in the same cycle, and no two valid entries ever hold the same tag.
- R2: A read is accepted when cpu_req and cpu_ready are both high. If the read hits, cpu_done pulses one cycle after acceptance with cpu_hit=1 and the stored word on cpu_rdata, and no memory transaction takes place.
- R3: A read miss issues one memory read (mem_req=1, mem_we=0, mem_addr set to the request address). In the cycle after mem_ack, cpu_done pulses with cpu_hit=0 and the fetched word on cpu_rdata. The word is installed, so a following read of the same word hits.
- R4: Every write issues exactly one memory write carrying the request address and data. cpu_done pulses in the cycle after mem_ack, with cpu_hit showing whether the word was resident. A write hit updates the stored word. A write miss allocates no entry.
- R5: A miss fills an invalid entry, the lowest-numbered one, whenever any entry is invalid. Valid entries are evicted only when all entries are valid.
- R6: With POLICY=REPL_LRU, the victim is the entry whose latest use is oldest. A fill, a read hit and a write hit all count as a use.
- R7: With POLICY=REPL_RR, the victim is the entry that was filled from memory longest ago.
- R8: With POLICY=REPL_RAND, the victim is the low log2(ENTRIES) bits of an 8-bit shift register. The register is seeded to 8'h01 by reset and shifts left every clock, taking in bit7^bit5^bit4^bit3. The value used is the one held at the edge that accepts the request.
- R9: cpu_ready is high only while the block is idle. It is low from the cycle after a miss or write is accepted until the cycle after mem_ack. mem_req and mem_addr stay steady until mem_ack.
- R10: After synchronous reset, every entry is invalid, cpu_ready=1, mem_req=0 and cpu_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed access was resident |
| cpu_rdata | output | 32 | Read result, valid with cpu_done |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench builds three four-entry copies, one per policy, and feeds them the same access stream. A reference model tracks use and fill times, so a wrong victim shows up later as an unexpected hit or miss. The stream includes the first fills into an empty cache, which would expose a block that evicts a valid entry while a free one exists. It includes a re-read right after an eviction, where a cyclic victim and an oldest-use victim differ. It includes a write hit followed by a read, which would return stale data if the local copy were not updated, and a write miss followed by a read, which would hit if writes allocated. Memory transaction counts catch a read hit that wrongly goes to memory and a write that skips memory.

// File: rtl/fac_pkg.sv
package fac_pkg;

    localparam int WORD_W = 32;
    localparam int TAG_W  = WORD_W - 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        REPL_LRU  = 2'd0,
        REPL_RR   = 2'd1,
        REPL_RAND = 2'd2
    } repl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    typedef struct packed {
        logic vld;
        tag_t tag;
        word_t data;
    } entry_t;

    typedef struct packed {
        word_t addr;
        word_t wdata;
    } cpu_cmd_t;

    function automatic tag_t addr_tag(input word_t a);
        return a[WORD_W-1:2];
    endfunction

    function automatic logic [7:0] lfsr_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/fa_tag_store.sv
module fa_tag_store
    import fac_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  tag_t                       lk_tag,
    output logic [ENTRIES-1:0]         match_vec,
    output logic [ENTRIES-1:0]         valid_vec,
    output logic [$clog2(ENTRIES)-1:0] hit_idx,
    output word_t                      hit_data,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  tag_t                       wr_tag,
    input  word_t                      wr_data
);
    localparam int IW = $clog2(ENTRIES);

    entry_t ents [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents[i] <= '0;
            end
        end else if (wr_en) begin
            ents[wr_idx] <= '{vld: 1'b1, tag: wr_tag, data: wr_data};
        end
    end

    // one comparator per entry, all evaluated in the same cycle
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign valid_vec[g] = ents[g].vld;
        assign match_vec[g] = ents[g].vld && (ents[g].tag == lk_tag);
    end

    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx  = IW'(i);
                hit_data = ents[i].data;
            end
        end
    end

endmodule

// File: rtl/fa_victim.sv
module fa_victim
    import fac_pkg::*;
#(
    parameter int    ENTRIES = 8,
    parameter repl_e POLICY  = REPL_LRU
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ENTRIES-1:0]         valid_vec,
    input  logic                       touch_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_idx,
    input  logic                       fill_en,
    input  logic [$clog2(ENTRIES)-1:0] fill_idx,
    output logic [$clog2(ENTRIES)-1:0] victim_idx
);
    localparam int IW = $clog2(ENTRIES);

    logic [IW-1:0] rank [ENTRIES];
    logic [IW-1:0] lru_idx;
    logic [IW-1:0] rr_ptr;
    logic [7:0]    lfsr;
    logic [IW-1:0] free_idx;
    logic          any_free;

    // rank 0 = most recent use, rank ENTRIES-1 = oldest
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                rank[i] <= IW'(ENTRIES - 1 - i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IW'(i) == touch_idx) begin
                    rank[i] <= '0;
                end else if (rank[i] < rank[touch_idx]) begin
                    rank[i] <= rank[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank[i] == IW'(ENTRIES - 1)) begin
                lru_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
            lfsr   <= 8'h01;
        end else begin
            lfsr <= lfsr_next(lfsr);
            if (fill_en) begin
                rr_ptr <= (fill_idx == IW'(ENTRIES - 1)) ? '0 : fill_idx + 1'b1;
            end
        end
    end

    always_comb begin
        any_free = ~&valid_vec;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IW'(i);
            end
        end
    end

    always_comb begin
        if (any_free) begin
            victim_idx = free_idx;
        end else begin
            unique case (POLICY)
                REPL_LRU: victim_idx = lru_idx;
                REPL_RR:  victim_idx = rr_ptr;
                default:  victim_idx = lfsr[IW-1:0];
            endcase
        end
    end

endmodule

// File: rtl/fa_cache.sv
module fa_cache
    import fac_pkg::*;
#(
    parameter int    ENTRIES = 8,
    parameter repl_e POLICY  = REPL_LRU
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic        cpu_done,
    output logic        cpu_hit,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int IW = $clog2(ENTRIES);

    state_e             state;
    cpu_cmd_t           cmd;
    logic [IW-1:0]      vic_q;

    logic               accept;
    tag_t               lk_tag;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic               lk_hit;
    logic [IW-1:0]      hit_idx;
    word_t              hit_data;
    logic               fill_en;
    logic               wr_en;
    logic [IW-1:0]      wr_idx;
    tag_t               wr_tag;
    word_t              wr_data;
    logic               touch_en;
    logic [IW-1:0]      victim_idx;

    assign accept   = cpu_req && (state == ST_IDLE);
    assign lk_tag   = addr_tag(cpu_addr);
    assign lk_hit   = |match_vec;
    assign fill_en  = (state == ST_FILL) && mem_ack;
    assign wr_en    = (accept && cpu_we && lk_hit) || fill_en;
    assign wr_idx   = fill_en ? vic_q : hit_idx;
    assign wr_tag   = fill_en ? addr_tag(cmd.addr) : lk_tag;
    assign wr_data  = fill_en ? mem_rdata : cpu_wdata;
    assign touch_en = (accept && lk_hit) || fill_en;

    fa_tag_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_tag    (lk_tag),
        .match_vec (match_vec),
        .valid_vec (valid_vec),
        .hit_idx   (hit_idx),
        .hit_data  (hit_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data)
    );

    fa_victim #(.ENTRIES(ENTRIES), .POLICY(POLICY)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .touch_en   (touch_en),
        .touch_idx  (wr_idx),
        .fill_en    (fill_en),
        .fill_idx   (vic_q),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd       <= '0;
            vic_q     <= '0;
            cpu_done  <= 1'b0;
            cpu_hit   <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd     <= '{addr: cpu_addr, wdata: cpu_wdata};
                        cpu_hit <= lk_hit;
                        if (cpu_we) begin
                            state <= ST_WRITE;
                        end else if (lk_hit) begin
                            cpu_done  <= 1'b1;
                            cpu_rdata <= hit_data;
                        end else begin
                            state <= ST_FILL;
                            vic_q <= victim_idx;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        state     <= ST_IDLE;
                        cpu_done  <= 1'b1;
                        cpu_rdata <= mem_rdata;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        state    <= ST_IDLE;
                        cpu_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (state == ST_IDLE);
    assign mem_req   = (state != ST_IDLE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;

endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
    parameter int ENTRIES = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       accept,
    input logic                       cpu_we,
    input logic                       lk_hit,
    input logic                       cpu_done,
    input logic                       cpu_hit,
    input logic                       cpu_ready,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic                       mem_ack,
    input logic [31:0]                mem_addr,
    input logic [ENTRIES-1:0]         match_vec,
    input logic [ENTRIES-1:0]         valid_vec,
    input logic                       fill_en,
    input logic [$clog2(ENTRIES)-1:0] vic_q
);

    p_single_match_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    p_hit_local_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpu_we && lk_hit) |=> (cpu_done && cpu_hit && !mem_req));

    p_fill_return_r3: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (cpu_done && !cpu_hit));

    p_write_through_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_we) |=> (mem_req && mem_we));

    p_free_first_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && valid_vec[vic_q]) |-> (&valid_vec));

    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((valid_vec & $past(valid_vec)) == $past(valid_vec)));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && (cpu_we || !lk_hit)) |=> !cpu_ready);

endmodule

bind fa_cache fa_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cpu_we    (cpu_we),
    .lk_hit    (lk_hit),
    .cpu_done  (cpu_done),
    .cpu_hit   (cpu_hit),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .fill_en   (fill_en),
    .vic_q     (vic_q)
);

// File: tb/sim_fa_cache.sv
`timescale 1ns/1ps
module sim_fa_cache;
    import fac_pkg::*;

    localparam int N  = 4;
    localparam int NP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;

    logic        rdy   [NP];
    logic        done  [NP];
    logic        hit   [NP];
    logic [31:0] rdata [NP];
    logic        mreq  [NP];
    logic        mwe   [NP];
    logic [31:0] maddr [NP];
    logic [31:0] mwd   [NP];
    logic        mack  [NP];
    logic [31:0] mrd   [NP];
    logic [1:0]  cnt   [NP];
    int          ack_cnt  [NP];
    int          done_cnt [NP];
    logic        ghit  [NP];
    logic [31:0] gdata [NP];

    logic [31:0] bmem [64];
    logic [7:0]  blfsr;
    logic [7:0]  snap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    fa_cache #(.ENTRIES(N), .POLICY(REPL_LRU)) u0 (
        .clk(clk), .rst(rst), .cpu_req(req), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_ready(rdy[0]), .cpu_done(done[0]), .cpu_hit(hit[0]), .cpu_rdata(rdata[0]),
        .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwd[0]),
        .mem_ack(mack[0]), .mem_rdata(mrd[0]));

    fa_cache #(.ENTRIES(N), .POLICY(REPL_RR)) u1 (
        .clk(clk), .rst(rst), .cpu_req(req), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_ready(rdy[1]), .cpu_done(done[1]), .cpu_hit(hit[1]), .cpu_rdata(rdata[1]),
        .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwd[1]),
        .mem_ack(mack[1]), .mem_rdata(mrd[1]));

    fa_cache #(.ENTRIES(N), .POLICY(REPL_RAND)) u2 (
        .clk(clk), .rst(rst), .cpu_req(req), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_ready(rdy[2]), .cpu_done(done[2]), .cpu_hit(hit[2]), .cpu_rdata(rdata[2]),
        .mem_req(mreq[2]), .mem_we(mwe[2]), .mem_addr(maddr[2]), .mem_wdata(mwd[2]),
        .mem_ack(mack[2]), .mem_rdata(mrd[2]));

    // memory models: ack two cycles after the request is seen, plus capture of completions
    for (genvar p = 0; p < NP; p++) begin : g_mem
        always @(posedge clk) begin
            if (rst) begin
                mack[p] <= 1'b0;
                cnt[p]  <= '0;
                mrd[p]  <= '0;
            end else if (mreq[p] && !mack[p]) begin
                if (cnt[p] == 2'd2) begin
                    mack[p] <= 1'b1;
                    cnt[p]  <= '0;
                    mrd[p]  <= bmem[maddr[p][7:2]];
                end else begin
                    cnt[p] <= cnt[p] + 2'd1;
                end
            end else begin
                mack[p] <= 1'b0;
            end
        end
        always @(posedge clk) begin
            if (rst) begin
                ack_cnt[p]  <= 0;
                done_cnt[p] <= 0;
            end else begin
                if (mack[p]) ack_cnt[p] <= ack_cnt[p] + 1;
                if (done[p]) begin
                    done_cnt[p] <= done_cnt[p] + 1;
                    ghit[p]     <= hit[p];
                    gdata[p]    <= rdata[p];
                end
            end
        end
    end

    // R8 reference shift register and the value seen at each acceptance edge
    always @(posedge clk) begin
        if (rst) blfsr <= 8'h01;
        else     blfsr <= {blfsr[6:0], blfsr[7] ^ blfsr[5] ^ blfsr[4] ^ blfsr[3]};
        if (req && rdy[2]) snap <= blfsr;
    end

    // reference model of residency per policy
    logic        mv [NP][N];
    logic [29:0] mt [NP][N];
    int          use_t  [NP][N];
    int          fill_t [NP][N];
    int          tstamp = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string pol_tag(input int p);
        if (p == 0) return "R6";
        if (p == 1) return "R7";
        return "R8";
    endfunction

    task automatic access(input bit we_i, input logic [31:0] a, input logic [31:0] d);
        bit pred [NP];
        int pidx [NP];
        int before_d [NP];
        int before_a [NP];
        int guard;
        bit all_done;
        for (int p = 0; p < NP; p++) begin
            pred[p] = 1'b0;
            pidx[p] = 0;
            for (int i = 0; i < N; i++) begin
                if (mv[p][i] && mt[p][i] == a[31:2]) begin
                    pred[p] = 1'b1;
                    pidx[p] = i;
                end
            end
            before_d[p] = done_cnt[p];
            before_a[p] = ack_cnt[p];
        end
        @(negedge clk);
        req = 1'b1; we = we_i; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (we_i || !pred[p]) begin
                // R9: busy after a miss or write is accepted
                check(rdy[p] == 1'b0, "R9", $sformatf("ready while busy p%0d", p),
                      32'(rdy[p]), 32'd0);
            end
        end
        guard = 0;
        all_done = 1'b0;
        while (!all_done && guard < 100) begin
            all_done = 1'b1;
            for (int p = 0; p < NP; p++) begin
                if (done_cnt[p] != before_d[p] + 1) all_done = 1'b0;
            end
            if (!all_done) begin
                @(negedge clk);
                guard++;
            end
        end
        for (int p = 0; p < NP; p++) begin
            string tg;
            tg = we_i ? "R4" : (pred[p] ? "R2" : "R3");
            check(done_cnt[p] == before_d[p] + 1, tg, $sformatf("done count p%0d", p),
                  32'(done_cnt[p] - before_d[p]), 32'd1);
            check(ghit[p] == pred[p], we_i ? tg : pol_tag(p),
                  $sformatf("hit flag p%0d addr %h", p, a), 32'(ghit[p]), 32'(pred[p]));
            if (!we_i) begin
                check(gdata[p] == bmem[a[7:2]], tg, $sformatf("read data p%0d addr %h", p, a),
                      gdata[p], bmem[a[7:2]]);
            end
            // R2: no memory for a read hit; R3/R4: exactly one transaction otherwise
            check(ack_cnt[p] - before_a[p] == ((we_i || !pred[p]) ? 1 : 0), tg,
                  $sformatf("memory transactions p%0d", p),
                  32'(ack_cnt[p] - before_a[p]), (we_i || !pred[p]) ? 32'd1 : 32'd0);
        end
        if (we_i) bmem[a[7:2]] = d;
        tstamp++;
        for (int p = 0; p < NP; p++) begin
            if (pred[p]) begin
                use_t[p][pidx[p]] = tstamp;
            end else if (!we_i) begin
                int v;
                v = -1;
                // R5: lowest invalid entry first
                for (int i = 0; i < N; i++) begin
                    if (!mv[p][i] && v < 0) v = i;
                end
                if (v < 0) begin
                    if (p == 2) begin
                        v = int'(snap[1:0]);
                    end else begin
                        v = 0;
                        for (int i = 1; i < N; i++) begin
                            if (p == 0 && use_t[p][i] < use_t[p][v]) v = i;
                            if (p == 1 && fill_t[p][i] < fill_t[p][v]) v = i;
                        end
                    end
                end
                mv[p][v]     = 1'b1;
                mt[p][v]     = a[31:2];
                use_t[p][v]  = tstamp;
                fill_t[p][v] = tstamp;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 32'h1000_0000 + i * 32'h0011_0003;
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < N; i++) begin
                mv[p][i] = 1'b0; mt[p][i] = '0; use_t[p][i] = 0; fill_t[p][i] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            // R10: reset state
            check(rdy[p] == 1'b1 && mreq[p] == 1'b0 && done[p] == 1'b0, "R10",
                  $sformatf("reset outputs p%0d", p),
                  {29'd0, rdy[p], mreq[p], done[p]}, 32'h4);
        end
        // fill an empty cache, then confirm every word is resident (R5, R1)
        for (int k = 0; k < 4; k++) access(1'b0, 32'(k * 4), '0);
        for (int k = 0; k < 4; k++) access(1'b0, 32'(k * 4 + 1), '0);
        // eviction: oldest use differs from oldest fill (R6, R7, R8)
        access(1'b0, 32'h0, '0);
        access(1'b0, 32'h10, '0);
        access(1'b0, 32'h0, '0);
        access(1'b0, 32'h4, '0);
        // write hit then read back; write miss then read (R4)
        access(1'b1, 32'h10, 32'hDEAD_0010);
        access(1'b0, 32'h10, '0);
        access(1'b1, 32'h80, 32'hBEEF_0080);
        access(1'b0, 32'h80, '0);
        // sweep over eight words with interleaved writes
        for (int k = 0; k < 64; k++) begin
            logic [31:0] wa;
            wa = 32'((((k * 5) + (k / 3)) % 8) * 4);
            access((k % 7) == 3, wa, 32'hC0DE_0000 ^ (32'(k) * 32'h0101_0101));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule